// File: doc/BRIEF.md
# ADC Conversion Sequencer with Edge-Triggered Auto Start

This block decides when an analog-to-digital converter starts a conversion and when that conversion ends. A conversion can begin in two ways. Software can write the start bit. Alternatively, a rising edge can arrive on one of several trigger inputs, chosen by a select code, while auto-triggering is enabled. One select code picks the block's own conversion-complete flag as the trigger source. Used that way, the converter runs back to back for as long as software clears the flag after each result.

On every start the block latches the channel select and drives a one-cycle start pulse to the converter. It also pulses a prescaler reset and restarts its internal timer. The timer counts `CONV_CLKS` prescaled periods, and each period is `PRESC_DIV` clock cycles long. At the end of the count the block clears its busy bit, emits a completion pulse and sets a sticky complete flag. The flag, ANDed with the interrupt enable, drives the interrupt request.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With `en_i`=1 and no conversion running, a 1 on `start_set_i` at a clock edge makes `busy_o` read 1 after that edge. The same edge raises `conv_start_o` and `presc_rst_o` for exactly one cycle and loads `chan_i` into `chan_o`.
- R2: `busy_o` stays 1 for exactly `PRESC_DIV*CONV_CLKS` cycles after the start edge and then returns to 0. `done_o` is 1 only in the first cycle after `busy_o` falls on completion.
- R3: While `en_i`=0, neither a start write nor a trigger edge begins a conversion, and `chan_o` keeps its value.
- R4: Dropping `en_i` during a conversion clears `busy_o` at the next edge and pulses `presc_rst_o`. The aborted conversion produces no `done_o` and leaves `flag_o` unchanged.
- R5: A change on `chan_i` during a conversion does not alter `chan_o`. The new value is latched only at the next start.
- R6: With `auto_en_i`=1, a 0-to-1 change of the selected source starts a conversion with the same outputs as in R1. Select code k < `NUM_TRIG` selects `trig_i[k]`, and code `NUM_TRIG` selects `flag_o`.
- R7: A start write or a trigger edge that arrives while `busy_o`=1 is ignored, and the running conversion keeps its original completion cycle.
- R8: A trigger level that is still 1 when a conversion completes does not start another conversion.
- R9: Edges on unselected trigger inputs, and any trigger edge while `auto_en_i`=0, start nothing.
- R10: Every completion sets `flag_o`, whatever the value of `irq_en_i`. A 1 on `flag_clr_i` clears the flag. `irq_o` is `flag_o` AND `irq_en_i`.
- R11: When the selected source is the flag, a completion that raises the flag starts the next conversion one cycle after `done_o`. A completion that finds the flag already set starts nothing.
- R12: After reset, `busy_o`, `flag_o`, `irq_o`, `done_o`, `conv_start_o` and `presc_rst_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable; 0 aborts and blocks conversions |
| start_set_i | input | 1 | Write-1 software start |
| auto_en_i | input | 1 | Auto-trigger enable |
| trig_sel_i | input | $clog2(NUM_TRIG+1) | Trigger source select |
| trig_i | input | NUM_TRIG | External trigger levels |
| chan_i | input | CH_W | Requested channel |
| flag_clr_i | input | 1 | Write-1 clear of complete flag |
| irq_en_i | input | 1 | Interrupt enable |
| busy_o | output | 1 | Start/busy status bit |
| conv_start_o | output | 1 | One-cycle start pulse to converter |
| presc_rst_o | output | 1 | One-cycle prescaler reset |
| chan_o | output | CH_W | Channel latched for the running conversion |
| done_o | output | 1 | One-cycle completion pulse |
| flag_o | output | 1 | Sticky conversion-complete flag |
| irq_o | output | 1 | Interrupt request |

## Verification
If the timer is corrupted, the completion pulse lands on the wrong cycle, and the bench compares each completion cycle against the cycle computed at start. An edge detector that holds a wrong previous value either starts an extra conversion, which shows one cycle later as an unexpected `busy_o` and later as a `done_o` with no matching entry, or misses a start, which leaves an entry unmatched. A wrong channel latch shows at the next completion as a mismatched `chan_o`. A flag that fails to set or clear shows on `irq_o` and in the self-retrigger chain within one conversion length.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  localparam int NUM_SRC = NUM_TRIG + 1,
  localparam int SEL_W   = cnt_width(NUM_SRC)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic                flag_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                rise_o
);
  logic [NUM_SRC-1:0] src;
  logic               sel_lvl;
  logic               prev_q;

  assign src = {flag_i, trig_i};

  always_comb begin
    sel_lvl = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_i == SEL_W'(i)) sel_lvl = src[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sel_lvl;
  end

  assign rise_o = sel_lvl & ~prev_q;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_seq_pkg::*;
#(
  parameter int PRESC_DIV = 8,
  parameter int CONV_CLKS = 13,
  localparam int PW = cnt_width(PRESC_DIV),
  localparam int CW = cnt_width(CONV_CLKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic last_o
);
  localparam logic [CW-1:0] CMAX = CW'(CONV_CLKS - 1);

  logic [PW-1:0] presc_q;
  logic [CW-1:0] cnt_q;
  logic          tick;

  generate
    if (PRESC_DIV > 1) begin : g_div
      localparam logic [PW-1:0] PMAX = PW'(PRESC_DIV - 1);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      presc_q <= '0;
        else if (clear_i) presc_q <= '0;
        else if (run_i)   presc_q <= (presc_q == PMAX) ? '0 : presc_q + 1'b1;
      end
      assign tick = run_i & (presc_q == PMAX);
    end else begin : g_nodiv
      assign presc_q = '0;
      assign tick    = run_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick)    cnt_q <= (cnt_q == CMAX) ? '0 : cnt_q + 1'b1;
  end

  assign last_o = tick & (cnt_q == CMAX);

  // R2: the count never passes its limit
  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_TRIG  = 4,
  parameter int CH_W      = 6,
  parameter int PRESC_DIV = 8,
  parameter int CONV_CLKS = 13,
  localparam int SEL_W    = cnt_width(NUM_TRIG + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                start_set_i,
  input  logic                auto_en_i,
  input  logic [SEL_W-1:0]    trig_sel_i,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic                flag_clr_i,
  input  logic                irq_en_i,
  output logic                busy_o,
  output logic                conv_start_o,
  output logic                presc_rst_o,
  output logic [CH_W-1:0]     chan_o,
  output logic                done_o,
  output logic                flag_o,
  output logic                irq_o
);
  logic busy_q, flag_q, done_q, start_q, prst_q;
  logic [CH_W-1:0] chan_q;
  logic trig_rise, start_go, finish, abort, conv_last;

  adc_trig_sel #(.NUM_TRIG(NUM_TRIG)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .flag_i (flag_q),
    .sel_i  (trig_sel_i),
    .rise_o (trig_rise)
  );

  adc_conv_timer #(.PRESC_DIV(PRESC_DIV), .CONV_CLKS(CONV_CLKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_go | ~en_i),
    .run_i   (busy_q),
    .last_o  (conv_last)
  );

  assign start_go = en_i & ~busy_q & (start_set_i | (auto_en_i & trig_rise));
  assign finish   = en_i & busy_q & conv_last;
  assign abort    = ~en_i & busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      start_q <= 1'b0;
      prst_q  <= 1'b0;
      chan_q  <= '0;
    end else begin
      start_q <= start_go;
      prst_q  <= start_go | abort;
      done_q  <= finish;
      if (!en_i)         busy_q <= 1'b0;
      else if (start_go) busy_q <= 1'b1;
      else if (finish)   busy_q <= 1'b0;
      if (start_go) chan_q <= chan_i;
    end
  end

  // completion sets, write-1 clears; set wins a tie
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (finish)     flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign busy_o       = busy_q;
  assign conv_start_o = start_q;
  assign presc_rst_o  = prst_q;
  assign chan_o       = chan_q;
  assign done_o       = done_q;
  assign flag_o       = flag_q;
  assign irq_o        = flag_q & irq_en_i;

  assert_start_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> conv_start_o && presc_rst_o);
  assert_done_after_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  assert_disable_stops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o && !done_o);
  assert_chan_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(chan_o));
  assert_flag_on_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> flag_o);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int NT = 3, CHW = 4, DIV = 2, CONV = 5, LEN = DIV * CONV;
  localparam int SELW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, start = 0, auto_en = 0, fclr = 0, irq_en = 0;
  logic [SELW-1:0] sel = '0;
  logic [NT-1:0] trig = '0;
  logic [CHW-1:0] chan = '0;
  logic busy, cstart, prst, done, flag, irq;
  logic [CHW-1:0] chan_q;

  int cyc = 0, checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { int ch; int at; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq_ctrl #(.NUM_TRIG(NT), .CH_W(CHW), .PRESC_DIV(DIV), .CONV_CLKS(CONV)) u_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_set_i(start), .auto_en_i(auto_en),
    .trig_sel_i(sel), .trig_i(trig), .chan_i(chan), .flag_clr_i(fclr), .irq_en_i(irq_en),
    .busy_o(busy), .conv_start_o(cstart), .presc_rst_o(prst), .chan_o(chan_q),
    .done_o(done), .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int ch);
    exp_t e;
    e.ch = ch; e.at = cyc + LEN;
    q.push_back(e);
  endtask

  // monitor: every completion must match the oldest expected item
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk(0, "R7 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.at, "R2 done cycle", cyc, e.at);
        chk(int'(chan_q) == e.ch, "R5 channel at done", chan_q, e.ch);
        chk(flag, "R10 flag on done", flag, 1);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_start(input int ch, input string req);
    chan = CHW'(ch); start = 1;
    @(negedge clk); start = 0;
    chk(busy && cstart && prst, req, {busy, cstart, prst}, 7);
    push(ch);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic pulse_clr();
    fclr = 1; @(negedge clk); fclr = 0;
  endtask

  initial begin
    idle(2);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !flag && !irq && !done && !cstart && !prst, "R12 reset state",
        {busy, flag, irq, done, cstart, prst}, 0);

    // software start, mid-run channel change and ignored restart
    en = 1;
    sw_start(5, "R1 sw start");
    chk(chan_q == 5, "R1 channel latch", chan_q, 5);
    idle(1);
    chk(!cstart && !prst, "R1 one-cycle pulses", {cstart, prst}, 0);
    chan = 9; idle(2);
    chk(chan_q == 5, "R5 channel deferred", chan_q, 5);
    start = 1; @(negedge clk); start = 0;
    chk(busy && !cstart, "R7 start while busy", {busy, cstart}, 2);
    wait_idle();
    idle(1);
    chk(!done, "R2 done one cycle", done, 0);
    chk(flag && !irq, "R10 flag without irq enable", {flag, irq}, 2);
    irq_en = 1; #1;
    chk(irq, "R10 irq follows enable", irq, 1);
    pulse_clr();
    chk(!flag && !irq, "R10 write-1 clear", {flag, irq}, 0);

    sw_start(9, "R1 second start");
    chk(chan_q == 9, "R5 new channel at start", chan_q, 9);
    wait_idle(); idle(2);
    pulse_clr();

    // disabled: nothing starts
    en = 0; chan = 2; start = 1; @(negedge clk); start = 0;
    chk(!busy && !cstart, "R3 start while disabled", busy, 0);
    chk(chan_q == 9, "R3 channel unchanged", chan_q, 9);
    auto_en = 1; sel = 0; trig[0] = 1; idle(1);
    chk(!busy, "R3 trigger while disabled", busy, 0);
    trig[0] = 0; auto_en = 0; idle(1);

    // abort
    en = 1;
    sw_start(3, "R1 start before abort");
    idle(3);
    en = 0; @(negedge clk);
    chk(!busy && prst, "R4 abort", {busy, prst}, 1);
    void'(q.pop_back());
    idle(LEN + 2);
    chk(!flag && !done, "R4 no completion after abort", flag, 0);
    en = 1;

    // auto trigger on source 1, edge during run, level held over completion
    auto_en = 1; sel = 1; chan = 7; trig[1] = 1;
    @(negedge clk);
    chk(busy && cstart && prst, "R6 trigger start", {busy, cstart, prst}, 7);
    push(7);
    idle(2); trig[1] = 0; idle(1); trig[1] = 1; idle(1);
    chk(!cstart, "R7 edge while busy", cstart, 0);
    wait_idle(); idle(LEN);
    chk(!busy, "R8 held level no retrigger", busy, 0);
    trig[1] = 0; idle(1);

    // unselected inputs and disabled auto mode
    trig[0] = 1; trig[2] = 1; idle(1);
    chk(!busy, "R9 unselected edges", busy, 0);
    trig = '0; auto_en = 0; idle(1); trig[1] = 1; idle(1);
    chk(!busy, "R9 auto disabled", busy, 0);
    trig = '0; idle(1);

    // flag as trigger source
    pulse_clr();
    sel = 2'(NT); auto_en = 1; idle(1);
    sw_start(2, "R1 start for chain");
    wait_done(); @(negedge clk);
    chk(busy && cstart, "R11 flag rise retriggers", {busy, cstart}, 3);
    push(2);
    wait_idle(); idle(LEN + 3);
    chk(!busy, "R11 set flag blocks retrigger", busy, 0);
    pulse_clr();
    sw_start(4, "R1 start after clear");
    wait_done(); @(negedge clk);
    chk(busy, "R11 retrigger after clear", busy, 1);
    push(4);
    wait_idle(); idle(3);
    chk(q.size() == 0, "R2 all completions seen", q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule